// File: doc/BRIEF.md
# Linked-Descriptor Display Fetch Engine

This block moves image data and colour-table data out of system memory for a display controller. Software never hands it a single buffer. It gives each channel a start pointer to a descriptor in memory. Each descriptor gives a source address, a byte count, a frame tag, a palette flag and a pointer to the next descriptor. The engine reads a descriptor, moves the region it points at, and then follows the link. This repeats until software clears the enable input.

For indexed colour, software builds two descriptors that point at each other, so a colour-table reload comes before every frame. For true colour, a single frame descriptor links to itself. For a dual-scan panel, a second channel follows its own self-linked descriptor for the lower half of the screen. The two channels take turns, one descriptor at a time. Words from a palette-flagged region go to a colour-table write port. Words from any other region go to a valid/ready pixel stream tagged with the channel number. When a frame region completes, the engine pulses an end-of-frame flag and keeps that descriptor's tag readable.

Top module: `frame_fetch_dma`

## Requirements
- R1: A descriptor is four 32-bit words at consecutive word addresses: link (byte address of the next descriptor), source byte address, frame tag, and command. In the command, bits [20:0] are the byte count (a multiple of 4) and bit 26 marks a palette region.
- R2: A memory read holds `mem_req` high and `mem_addr` unchanged until a cycle with `mem_ack` high. `mem_rdata` is taken in that cycle.
- R3: Each word of a palette region is written once on the colour-table port. The word index starts at 0 for every palette region and steps by one. No such word appears on the pixel stream, and a palette region raises no end-of-frame pulse.
- R4: The words of a frame region appear on the pixel stream in ascending address order, each exactly once.
- R5: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_data` and `pix_chan` stay unchanged.
- R6: After a region completes, that channel's next descriptor is the link word. Both a two-descriptor alternating chain and a self-linked descriptor repeat without end.
- R7: When a frame region of channel c completes, `eof[c]` pulses for one cycle and `frame_id[c]` takes that descriptor's tag. `frame_id[c]` changes at no other time.
- R8: When `dual_scan` is 1, the channels alternate one descriptor at a time, starting with channel 0, and `pix_chan` carries the channel (1 for the lower panel). When `dual_scan` is 0, only channel 0 runs.
- R9: If `enable` is cleared during a transfer, the current region still completes in full. The engine then goes idle and issues no further reads.
- R10: Start pointers are sampled only when an idle engine sees `enable` high. Changes on `start_ptr` while it runs have no effect.
- R11: After reset, `mem_req`, `pix_valid`, `pal_we`, `eof` and `active` are all 0.
- R12: `active` is high from the cycle after an idle engine sees `enable` until it returns to idle. While it is low, no memory read and no pixel word is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; cleared to stop at the next region end |
| dual_scan | input | 1 | 1 = two channels alternate (upper/lower panel) |
| start_ptr | input | NUM_CH x AW | First descriptor address per channel |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the word requested |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| pix_valid | output | 1 | Pixel word offered |
| pix_ready | input | 1 | Consumer accepts the pixel word |
| pix_data | output | 32 | Pixel word |
| pix_chan | output | CH_W | Channel that fetched the word |
| pal_we | output | 1 | Colour-table write strobe |
| pal_addr | output | PAL_AW | Colour-table word index |
| pal_wdata | output | 32 | Colour-table word (two 16-bit entries) |
| eof | output | NUM_CH | One-cycle end-of-frame pulse per channel |
| frame_id | output | NUM_CH x 32 | Tag of the last completed frame per channel |
| active | output | 1 | Engine not idle |

## Verification
Results follow stimulus at these rising edges:
- A colour-table write is visible from the edge after the acknowledged read.
- A pixel word is offered from the edge after its acknowledged read and stays offered until the edge where it is accepted.
- The end-of-frame pulse and the new tag appear two edges after the last pixel of a region is accepted.
- `active` rises one edge after `enable` is seen while idle.

Memory responses, ready stalls and all comparisons happen at the falling edge. Each scoreboard queue is popped at the moment its output shows a completed handshake or strobe, so order is checked without fixing the wait-state count. The bench drops `enable` in the same falling-edge window where it sees an end-of-frame pulse, which lands exactly on the engine's descriptor-boundary decision. After that, it checks for 20 cycles that no read and no pixel word appear.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_DESC,
      ST_DATA,
      ST_HOLD,
      ST_FIN
   } ffd_state_t;

   function automatic int ch_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ffd_chan_bank.sv
module ffd_chan_bank
   import ffd_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int AW     = 32,
   localparam int CH_W  = ch_bits(NUM_CH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [NUM_CH-1:0][AW-1:0]     start_ptr,
   input  logic                          adv,
   input  logic [CH_W-1:0]               adv_ch,
   input  logic [AW-1:0]                 adv_link,
   input  logic                          frame_done,
   input  logic [WORD_W-1:0]             frame_tag,
   output logic [NUM_CH-1:0][AW-1:0]     cur_ptr,
   output logic [NUM_CH-1:0]             eof,
   output logic [NUM_CH-1:0][WORD_W-1:0] tag
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = adv && (adv_ch == CH_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cur_ptr[c] <= '0;
            eof[c]     <= 1'b0;
            tag[c]     <= '0;
         end else begin
            eof[c] <= 1'b0;
            if (load) begin
               cur_ptr[c] <= start_ptr[c];
            end else if (hit) begin
               cur_ptr[c] <= adv_link;
               if (frame_done) begin
                  tag[c] <= frame_tag;
                  eof[c] <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ffd_engine.sv
module ffd_engine
   import ffd_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int AW      = 32,
   parameter int LEN_W   = 21,
   parameter int PAL_BIT = 26,
   parameter int PAL_AW  = 8,
   localparam int CH_W   = ch_bits(NUM_CH),
   localparam int CNT_W  = LEN_W - 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      enable,
   input  logic                      dual_scan,
   input  logic [NUM_CH-1:0][AW-1:0] cur_ptr,
   output logic                      load,
   output logic                      adv,
   output logic [CH_W-1:0]           adv_ch,
   output logic [AW-1:0]             adv_link,
   output logic                      frame_done,
   output logic [WORD_W-1:0]         frame_tag,
   output logic                      mem_req,
   output logic [AW-1:0]             mem_addr,
   input  logic                      mem_ack,
   input  logic [WORD_W-1:0]         mem_rdata,
   output logic                      pix_valid,
   input  logic                      pix_ready,
   output logic [WORD_W-1:0]         pix_data,
   output logic [CH_W-1:0]           pix_chan,
   output logic                      pal_we,
   output logic [PAL_AW-1:0]         pal_addr,
   output logic [WORD_W-1:0]         pal_wdata,
   output logic                      active
);
   ffd_state_t        state;
   logic [CH_W-1:0]   cur, nxt_cur;
   logic [1:0]        widx;
   logic [AW-1:0]     link_q, src_q, addr_q;
   logic [WORD_W-1:0] tag_q;
   logic [CNT_W-1:0]  remain;
   logic              is_pal;
   logic [PAL_AW-1:0] pal_idx;

   if (NUM_CH == 1) begin : g_one_ch
      assign nxt_cur = '0;
   end else begin : g_rotate
      assign nxt_cur = dual_scan ? CH_W'(cur + 1'b1) : cur;
   end

   always_comb begin
      load       = (state == ST_IDLE) && enable;
      adv        = (state == ST_FIN);
      adv_ch     = cur;
      adv_link   = link_q;
      frame_done = (state == ST_FIN) && !is_pal;
      frame_tag  = tag_q;
      mem_req    = (state == ST_DESC) || (state == ST_DATA);
      mem_addr   = (state == ST_DESC) ? cur_ptr[cur] + AW'({widx, 2'b00}) : addr_q;
      pix_chan   = cur;
      active     = (state != ST_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur       <= '0;
         widx      <= '0;
         link_q    <= '0;
         src_q     <= '0;
         addr_q    <= '0;
         tag_q     <= '0;
         remain    <= '0;
         is_pal    <= 1'b0;
         pal_idx   <= '0;
         pix_valid <= 1'b0;
         pix_data  <= '0;
         pal_we    <= 1'b0;
         pal_addr  <= '0;
         pal_wdata <= '0;
      end else begin
         pal_we <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               cur <= '0;
               if (enable) state <= ST_PICK;
            end
            ST_PICK: begin
               widx <= '0;
               state <= enable ? ST_DESC : ST_IDLE;
            end
            ST_DESC: if (mem_ack) begin
               widx <= widx + 2'd1;
               unique case (widx)
                  2'd0: link_q <= AW'(mem_rdata);
                  2'd1: src_q  <= AW'(mem_rdata);
                  2'd2: tag_q  <= mem_rdata;
                  default: begin
                     addr_q  <= src_q;
                     remain  <= mem_rdata[LEN_W-1:2];
                     is_pal  <= mem_rdata[PAL_BIT];
                     pal_idx <= '0;
                     state   <= (mem_rdata[LEN_W-1:2] == '0) ? ST_FIN : ST_DATA;
                  end
               endcase
            end
            ST_DATA: if (mem_ack) begin
               addr_q <= addr_q + AW'(4);
               remain <= remain - CNT_W'(1);
               if (is_pal) begin
                  pal_we    <= 1'b1;
                  pal_addr  <= pal_idx;
                  pal_wdata <= mem_rdata;
                  pal_idx   <= pal_idx + PAL_AW'(1);
                  if (remain == CNT_W'(1)) state <= ST_FIN;
               end else begin
                  pix_valid <= 1'b1;
                  pix_data  <= mem_rdata;
                  state     <= ST_HOLD;
               end
            end
            ST_HOLD: if (pix_ready) begin
               pix_valid <= 1'b0;
               state     <= (remain == '0) ? ST_FIN : ST_DATA;
            end
            default: begin
               cur   <= nxt_cur;
               state <= ST_PICK;
            end
         endcase
      end
   end
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma
   import ffd_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int AW      = 32,
   parameter int LEN_W   = 21,
   parameter int PAL_BIT = 26,
   parameter int PAL_AW  = 8,
   localparam int CH_W   = ch_bits(NUM_CH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enable,
   input  logic                          dual_scan,
   input  logic [NUM_CH-1:0][AW-1:0]     start_ptr,
   output logic                          mem_req,
   output logic [AW-1:0]                 mem_addr,
   input  logic                          mem_ack,
   input  logic [WORD_W-1:0]             mem_rdata,
   output logic                          pix_valid,
   input  logic                          pix_ready,
   output logic [WORD_W-1:0]             pix_data,
   output logic [CH_W-1:0]               pix_chan,
   output logic                          pal_we,
   output logic [PAL_AW-1:0]             pal_addr,
   output logic [WORD_W-1:0]             pal_wdata,
   output logic [NUM_CH-1:0]             eof,
   output logic [NUM_CH-1:0][WORD_W-1:0] frame_id,
   output logic                          active
);
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("frame_fetch_dma: NUM_CH must be 1 or 2");
   end
   if (LEN_W < 3 || LEN_W > PAL_BIT) begin : g_bad_len
      $error("frame_fetch_dma: LEN_W must lie in 3..PAL_BIT");
   end
   if (PAL_BIT > WORD_W - 1 || AW > WORD_W) begin : g_bad_cmd
      $error("frame_fetch_dma: PAL_BIT and AW must fit a descriptor word");
   end

   logic                      load, adv, frame_done;
   logic [CH_W-1:0]           adv_ch;
   logic [AW-1:0]             adv_link;
   logic [WORD_W-1:0]         frame_tag;
   logic [NUM_CH-1:0][AW-1:0] cur_ptr;

   ffd_chan_bank #(.NUM_CH(NUM_CH), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(load), .start_ptr(start_ptr),
      .adv(adv), .adv_ch(adv_ch), .adv_link(adv_link),
      .frame_done(frame_done), .frame_tag(frame_tag),
      .cur_ptr(cur_ptr), .eof(eof), .tag(frame_id)
   );

   ffd_engine #(.NUM_CH(NUM_CH), .AW(AW), .LEN_W(LEN_W), .PAL_BIT(PAL_BIT),
                .PAL_AW(PAL_AW)) u_eng (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dual_scan(dual_scan),
      .cur_ptr(cur_ptr), .load(load), .adv(adv), .adv_ch(adv_ch),
      .adv_link(adv_link), .frame_done(frame_done), .frame_tag(frame_tag),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .pix_data(pix_data), .pix_chan(pix_chan), .pal_we(pal_we),
      .pal_addr(pal_addr), .pal_wdata(pal_wdata), .active(active)
   );
endmodule

// File: rtl/ffd_checker.sv
module ffd_checker #(
   parameter int NUM_CH = 2,
   parameter int AW     = 32,
   parameter int CH_W   = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     enable,
   input logic                     active,
   input logic                     mem_req,
   input logic                     mem_ack,
   input logic [AW-1:0]            mem_addr,
   input logic                     pix_valid,
   input logic                     pix_ready,
   input logic [31:0]              pix_data,
   input logic [CH_W-1:0]          pix_chan,
   input logic                     pal_we,
   input logic [NUM_CH-1:0]        eof,
   input logic [NUM_CH-1:0][31:0]  frame_id
);
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   a_r5_pix_held: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_chan));

   a_r3_pal_not_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      pal_we |-> !pix_valid);

   a_r7_single_eof: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eof));

   a_r9_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !active |=> !active);

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !mem_req && !pix_valid);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_tag
      a_r7_tag_only_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(frame_id[c]) |-> eof[c]);
      a_r7_eof_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         eof[c] |=> !eof[c]);
   end
endmodule

bind frame_fetch_dma ffd_checker #(.NUM_CH(NUM_CH), .AW(AW), .CH_W(CH_W)) u_ffd_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .active(active),
   .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
   .pix_chan(pix_chan), .pal_we(pal_we), .eof(eof), .frame_id(frame_id)
);

// File: tb/frame_fetch_dma_test.sv
`timescale 1ns/1ps
module frame_fetch_dma_test;
   localparam int NCH = 2;
   localparam logic [31:0] PAL_FLAG = 32'h0400_0000;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, dual_scan = 1'b0;
   logic [NCH-1:0][31:0] start_ptr = '0;
   logic mem_req, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic pix_valid, pix_ready = 1'b0;
   logic [31:0] pix_data;
   logic [0:0] pix_chan;
   logic pal_we;
   logic [7:0] pal_addr;
   logic [31:0] pal_wdata;
   logic [NCH-1:0] eof;
   logic [NCH-1:0][31:0] frame_id;
   logic active;

   frame_fetch_dma uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dual_scan(dual_scan),
      .start_ptr(start_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
      .pix_ready(pix_ready), .pix_data(pix_data), .pix_chan(pix_chan),
      .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
      .eof(eof), .frame_id(frame_id), .active(active)
   );

   always #5 clk = ~clk;

   int tests = 0, fails = 0, cyc = 0, nack = 0, wcnt = 0;
   bit stall_on = 1'b1, waited = 1'b0, done = 1'b0;
   logic [31:0] held_addr;
   logic [31:0] mem [0:1023];
   logic [32:0] exp_pix[$];
   logic [39:0] exp_pal[$];
   logic [31:0] exp_tag0[$], exp_tag1[$];
   logic [32:0] pe;
   logic [39:0] qe;
   logic [31:0] te;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // memory model with varying wait states; R2 address hold check
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; wcnt = 0; waited = 1'b0;
      end else if (mem_req) begin
         if (waited) check(mem_addr == held_addr, "R2", "address moved while waiting",
                           64'(mem_addr), 64'(held_addr));
         if (wcnt == 0) begin
            check(mem_addr < 32'd4096, "R2", "read outside memory", 64'(mem_addr), 0);
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[11:2]];
            nack++;
            wcnt   = nack % 3;
            waited = 1'b0;
         end else begin
            mem_ack   = 1'b0;
            wcnt--;
            waited    = 1'b1;
            held_addr = mem_addr;
         end
      end else begin
         if (waited) check(1'b0, "R2", "request dropped before ack", 0, 1);
         mem_ack = 1'b0;
         waited  = 1'b0;
      end
   end

   // ready pattern and scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      pix_ready = stall_on ? ((cyc % 4) != 1) : 1'b1;
      if (rst_n) begin
         if (pix_valid && pix_ready) begin
            if (exp_pix.size() == 0)
               check(1'b0, "R3 R4", "unexpected pixel word", 64'({pix_chan, pix_data}), 0);
            else begin
               pe = exp_pix.pop_front();
               check({pix_chan, pix_data} == pe, "R1 R4 R6 R8", "pixel word/channel",
                     64'({pix_chan, pix_data}), 64'(pe));
            end
         end
         if (pal_we) begin
            if (exp_pal.size() == 0)
               check(1'b0, "R3", "unexpected palette write", 64'({pal_addr, pal_wdata}), 0);
            else begin
               qe = exp_pal.pop_front();
               check({pal_addr, pal_wdata} == qe, "R3", "palette index/word",
                     64'({pal_addr, pal_wdata}), 64'(qe));
            end
         end
         if (eof[0]) begin
            if (exp_tag0.size() == 0) check(1'b0, "R7", "unexpected eof ch0", 64'(frame_id[0]), 0);
            else begin
               te = exp_tag0.pop_front();
               check(frame_id[0] == te, "R7", "ch0 frame tag", 64'(frame_id[0]), 64'(te));
            end
         end
         if (eof[1]) begin
            if (exp_tag1.size() == 0) check(1'b0, "R7 R8", "unexpected eof ch1", 64'(frame_id[1]), 0);
            else begin
               te = exp_tag1.pop_front();
               check(frame_id[1] == te, "R7 R8", "ch1 frame tag", 64'(frame_id[1]), 64'(te));
            end
         end
      end
   end

   task automatic put_desc(input int a, input logic [31:0] lnk, input logic [31:0] src,
                           input logic [31:0] tg, input logic [31:0] cmd);
      mem[a/4] = lnk; mem[a/4+1] = src; mem[a/4+2] = tg; mem[a/4+3] = cmd;
   endtask

   task automatic push_frame(input int ch, input int src, input int words, input logic [31:0] tg);
      for (int i = 0; i < words; i++) exp_pix.push_back({1'(ch), mem[src/4+i]});
      if (ch == 0) exp_tag0.push_back(tg); else exp_tag1.push_back(tg);
   endtask

   task automatic push_pal(input int src, input int words);
      for (int i = 0; i < words; i++) exp_pal.push_back({8'(i), mem[src/4+i]});
   endtask

   task automatic run_until_eof(input int ch, input int n);
      int seen = 0;
      enable = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(active, "R12", "active after enable", 64'(active), 1);
      while (seen < n) begin
         @(negedge clk);
         if (eof[ch]) seen++;
      end
      enable = 1'b0;
   endtask

   task automatic expect_stop();
      int t = 0;
      while (active && t < 3000) begin @(negedge clk); t++; end
      check(!active, "R9 R12", "engine idle after enable cleared", 64'(active), 0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check(!mem_req && !pix_valid, "R9 R12", "quiet while idle",
               64'({mem_req, pix_valid}), 0);
      end
      check(exp_pix.size() == 0, "R4 R9", "pixel words left undelivered", 64'(exp_pix.size()), 0);
      check(exp_pal.size() == 0, "R3", "palette writes missing", 64'(exp_pal.size()), 0);
      check(exp_tag0.size() == 0 && exp_tag1.size() == 0, "R7", "eof pulses missing",
            64'(exp_tag0.size() + exp_tag1.size()), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R12", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0001_9E37);

      // R11: reset state
      repeat (3) @(negedge clk);
      check(!mem_req && !pix_valid && !pal_we && eof == '0 && !active, "R11",
            "outputs during reset", 64'({mem_req, pix_valid, pal_we, eof, active}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!mem_req && !pix_valid && !active && frame_id == '0, "R11", "outputs after reset",
            64'({mem_req, pix_valid, active}), 0);

      // Indexed: palette <-> frame chain, two frames (R1 R3 R6 R10)
      put_desc(32'h1E0, 32'h1F0, 32'h100, 32'hA5, 32'd64);
      put_desc(32'h1F0, 32'h1E0, 32'h200, 32'h11, PAL_FLAG | 32'd32);
      push_pal(32'h200, 8);  push_frame(0, 32'h100, 16, 32'hA5);
      push_pal(32'h200, 8);  push_frame(0, 32'h100, 16, 32'hA5);
      start_ptr[0] = 32'h1F0;
      @(negedge clk);
      fork
         run_until_eof(0, 2);
         begin repeat (12) @(negedge clk); start_ptr[0] = 32'h3E0; end  // R10: ignored
      join
      expect_stop();
      check(frame_id[0] == 32'hA5, "R7", "tag kept after palette fetch", 64'(frame_id[0]), 32'hA5);

      // True colour: self-linked frame, stop midway through second (R6 R9 R5)
      put_desc(32'h3E0, 32'h3E0, 32'h400, 32'h77, 32'd128);
      push_frame(0, 32'h400, 32, 32'h77);
      push_frame(0, 32'h400, 32, 32'h77);
      start_ptr[0] = 32'h3E0;
      enable = 1'b1;
      begin
         int seen = 0;
         while (seen < 1) begin @(negedge clk); if (eof[0]) seen++; end
         while (!(mem_req && mem_addr == 32'h428)) @(negedge clk);
         enable = 1'b0;
      end
      expect_stop();
      check(frame_id[0] == 32'h77, "R7", "true-colour tag", 64'(frame_id[0]), 32'h77);

      // Dual scan: channels alternate per descriptor (R8)
      put_desc(32'h7E0, 32'h7E0, 32'h800, 32'h31, 32'd64);
      put_desc(32'h7D0, 32'h7D0, 32'h840, 32'h32, 32'd64);
      push_frame(0, 32'h800, 16, 32'h31); push_frame(1, 32'h840, 16, 32'h32);
      push_frame(0, 32'h800, 16, 32'h31); push_frame(1, 32'h840, 16, 32'h32);
      start_ptr[0] = 32'h7E0;
      start_ptr[1] = 32'h7D0;
      dual_scan = 1'b1;
      stall_on  = 1'b0;
      @(negedge clk);
      run_until_eof(1, 2);
      expect_stop();
      check(frame_id[1] == 32'h32 && frame_id[0] == 32'h31, "R7 R8", "both panel tags",
            64'({frame_id[1], frame_id[0]}), 64'h0000_0032_0000_0031);

      finish_run();
   end
endmodule